// File: doc/BRIEF.md
# Narrow-to-Wide Memory Bus Bridge

This block joins a 32-bit memory-mapped master to a 64-bit memory-mapped slave. Every narrow read or write becomes exactly one access on the wide side. The narrow address arrives in bytes. It is converted to a 64-bit word address, and bit 2 of that address picks which half of the wide word is used. A 64-bit quantity therefore travels as two narrow accesses, at byte offsets 0x0 and 0x4, and both land on the same wide word.

The narrow 4-bit byte-enable is steered into either the low or the high nibble of the 8-bit wide byte-enable. The write data is copied onto both halves of the wide bus, so the enabled lanes always carry the correct bytes. On reads, the half selected by the address captured when the read was accepted is returned to the master. 8-bit and 16-bit accesses are supported when their byte-enable is aligned to its own width. Any other byte-enable pattern is refused: the access is not forwarded, and the master gets a one-cycle acknowledge with an error flag.

Only one access is in flight at a time. The master is held with its wait-request until the wide slave has accepted the access. The wide request stays frozen while the slave stalls.

Top module: `bus_width_bridge`

## Requirements
- R1: After reset the wide side shows no read and no write, the error flag is low, and the narrow wait-request is high. The wide read and write strobes are never high together.
- R2: The wide word address equals the narrow byte address shifted right by 3.
- R3: The wide byte-enable is the narrow byte-enable placed in bits 3:0 when narrow address bit 2 is 0, and in bits 7:4 when it is 1. The other nibble is zero.
- R4: During a wide write, the 32-bit write data appears on both bits 31:0 and bits 63:32 of the wide write bus.
- R5: A read returns wide bits 63:32 when address bit 2 was 1 at acceptance, and bits 31:0 otherwise. A change of the narrow address after acceptance does not alter the half returned.
- R6: A narrow byte-enable outside {1111, 0011, 1100, 0001, 0010, 0100, 1000} causes no wide access. The master then sees wait-request low for exactly one cycle, with the error flag high in that cycle, and the addressed memory is left unchanged.
- R7: While the wide slave holds its wait-request high, the wide strobe, address, byte-enable and write data stay unchanged and the master stays stalled. The wide strobe is high for exactly (stall cycles + 1) cycles.
- R8: The cycle after the wide slave accepts an access, the narrow wait-request is low for exactly one cycle, with the error flag low. With no request pending, wait-request is high again in the next cycle.
- R9: Legal 8-bit (single bit) and 16-bit (0011, 1100) byte-enables are forwarded and update only the addressed bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| nAddr | input | ADDR_W-2 | Narrow byte address, bits ADDR_W-1:2 |
| nRead | input | 1 | Narrow read request |
| nWrite | input | 1 | Narrow write request |
| nByteEn | input | 4 | Narrow byte-enable |
| nWriteData | input | 32 | Narrow write data |
| nReadData | output | 32 | Narrow read data, valid while wait-request is low |
| nWaitReq | output | 1 | Stall to the narrow master; low for one cycle to complete |
| nError | output | 1 | High during the completion cycle of a refused access |
| wAddr | output | ADDR_W-3 | Wide word address |
| wRead | output | 1 | Wide read strobe |
| wWrite | output | 1 | Wide write strobe |
| wByteEn | output | 8 | Wide byte-enable |
| wWriteData | output | 64 | Wide write data |
| wReadData | input | 64 | Wide read data, sampled when wide wait-request is low |
| wWaitReq | input | 1 | Stall from the wide slave |

## Verification
The hardest case to reach is a read that stays pending on the wide side while the narrow address moves. A legal master never changes its address during a stall, so this case does not arise on its own. The bench stalls the wide slave for several cycles and flips narrow address bit 2 in the first stall cycle. It then checks that the half returned still follows the address held at acceptance. Refused byte-enable patterns are checked through a later read of the same word, which shows that memory was not touched.

// File: rtl/bwb_pkg.sv
package bwb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BUSY,
    ST_DONE,
    ST_FAULT
  } bridgeState_e;

  typedef struct packed {
    logic loadReq;
    logic captureRd;
    logic wideActive;
    logic ack;
    logic fault;
  } ctrlStrobe_t;

  // True when the mask is a contiguous run of w set bits (w a power of two),
  // starting at a multiple of w and lying inside nBytes lanes.
  function automatic logic isAlignedMask(input logic [15:0] mask, input int unsigned nBytes);
    logic hit;
    logic [15:0] pattern;
    hit = 1'b0;
    for (int w = 1; w <= 16; w = w * 2) begin
      for (int off = 0; off < 16; off = off + w) begin
        if ((w <= int'(nBytes)) && (off + w <= int'(nBytes))) begin
          pattern = 16'((32'd1 << w) - 32'd1) << off;
          if (mask == pattern) hit = 1'b1;
        end
      end
    end
    return hit;
  endfunction

endpackage

// File: rtl/bwb_ctrl.sv
module bwb_ctrl
  import bwb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqLegal,
  input  logic        wWaitReq,
  output ctrlStrobe_t strobe
);

  bridgeState_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          if (reqLegal) begin
            strobe.loadReq = 1'b1;
            stateD = ST_BUSY;
          end else begin
            stateD = ST_FAULT;
          end
        end
      end
      ST_BUSY: begin
        strobe.wideActive = 1'b1;
        if (!wWaitReq) begin
          strobe.captureRd = 1'b1;
          stateD = ST_DONE;
        end
      end
      ST_DONE: begin
        strobe.ack = 1'b1;
        stateD = ST_IDLE;
      end
      ST_FAULT: begin
        strobe.ack   = 1'b1;
        strobe.fault = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/bwb_datapath.sv
module bwb_datapath
  import bwb_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NARROW_W = 32,
  localparam int NB      = NARROW_W / 8,
  localparam int SEL_BIT = $clog2(NB),
  localparam int WIDE_W  = 2 * NARROW_W,
  localparam int WB      = 2 * NB,
  localparam int WADDR_W = ADDR_W - SEL_BIT - 1
)(
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             strobe,
  input  logic [ADDR_W-1:SEL_BIT] nAddr,
  input  logic                    nRead,
  input  logic                    nWrite,
  input  logic [NB-1:0]           nByteEn,
  input  logic [NARROW_W-1:0]     nWriteData,
  input  logic [WIDE_W-1:0]       wReadData,
  output logic                    reqValid,
  output logic                    reqLegal,
  output logic [NARROW_W-1:0]     nReadData,
  output logic                    nWaitReq,
  output logic                    nError,
  output logic [WADDR_W-1:0]      wAddr,
  output logic                    wRead,
  output logic                    wWrite,
  output logic [WB-1:0]           wByteEn,
  output logic [WIDE_W-1:0]       wWriteData
);

  logic [ADDR_W-1:SEL_BIT] addrQ;
  logic [NB-1:0]           beQ;
  logic [NARROW_W-1:0]     wdataQ;
  logic                    isWriteQ;
  logic [NARROW_W-1:0]     rdataQ;
  logic [NARROW_W-1:0]     rdHalf;
  logic                    halfSel;

  assign reqValid = nRead | nWrite;
  assign reqLegal = isAlignedMask(16'(nByteEn), NB);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      beQ      <= '0;
      wdataQ   <= '0;
      isWriteQ <= 1'b0;
      rdataQ   <= '0;
    end else begin
      if (strobe.loadReq) begin
        addrQ    <= nAddr;
        beQ      <= nByteEn;
        wdataQ   <= nWriteData;
        isWriteQ <= nWrite;
      end
      if (strobe.captureRd && !isWriteQ) rdataQ <= rdHalf;
    end
  end

  assign halfSel = addrQ[SEL_BIT];
  assign wAddr   = addrQ[ADDR_W-1:SEL_BIT+1];
  assign wRead   = strobe.wideActive & ~isWriteQ;
  assign wWrite  = strobe.wideActive &  isWriteQ;

  for (genvar lane = 0; lane < 2; lane++) begin : g_lane
    assign wByteEn[lane*NB +: NB] =
      (strobe.wideActive && (halfSel == 1'(lane))) ? beQ : '0;
    assign wWriteData[lane*NARROW_W +: NARROW_W] = wdataQ;
  end

  assign rdHalf    = halfSel ? wReadData[WIDE_W-1:NARROW_W] : wReadData[NARROW_W-1:0];
  assign nReadData = rdataQ;
  assign nWaitReq  = ~strobe.ack;
  assign nError    = strobe.fault;

endmodule

// File: rtl/bus_width_bridge.sv
module bus_width_bridge
  import bwb_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NARROW_W = 32,
  localparam int NB      = NARROW_W / 8,
  localparam int SEL_BIT = $clog2(NB),
  localparam int WIDE_W  = 2 * NARROW_W,
  localparam int WB      = 2 * NB,
  localparam int WADDR_W = ADDR_W - SEL_BIT - 1
)(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:SEL_BIT] nAddr,
  input  logic                    nRead,
  input  logic                    nWrite,
  input  logic [NB-1:0]           nByteEn,
  input  logic [NARROW_W-1:0]     nWriteData,
  output logic [NARROW_W-1:0]     nReadData,
  output logic                    nWaitReq,
  output logic                    nError,
  output logic [WADDR_W-1:0]      wAddr,
  output logic                    wRead,
  output logic                    wWrite,
  output logic [WB-1:0]           wByteEn,
  output logic [WIDE_W-1:0]       wWriteData,
  input  logic [WIDE_W-1:0]       wReadData,
  input  logic                    wWaitReq
);

  ctrlStrobe_t strobe;
  logic        reqValid;
  logic        reqLegal;

  bwb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqLegal (reqLegal),
    .wWaitReq (wWaitReq),
    .strobe   (strobe)
  );

  bwb_datapath #(
    .ADDR_W   (ADDR_W),
    .NARROW_W (NARROW_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .nAddr      (nAddr),
    .nRead      (nRead),
    .nWrite     (nWrite),
    .nByteEn    (nByteEn),
    .nWriteData (nWriteData),
    .wReadData  (wReadData),
    .reqValid   (reqValid),
    .reqLegal   (reqLegal),
    .nReadData  (nReadData),
    .nWaitReq   (nWaitReq),
    .nError     (nError),
    .wAddr      (wAddr),
    .wRead      (wRead),
    .wWrite     (wWrite),
    .wByteEn    (wByteEn),
    .wWriteData (wWriteData)
  );

endmodule

// File: rtl/bwb_checker.sv
module bwb_checker #(
  parameter int ADDR_W   = 16,
  parameter int NARROW_W = 32,
  localparam int NB      = NARROW_W / 8,
  localparam int SEL_BIT = $clog2(NB),
  localparam int WIDE_W  = 2 * NARROW_W,
  localparam int WB      = 2 * NB,
  localparam int WADDR_W = ADDR_W - SEL_BIT - 1
)(
  input logic               clk,
  input logic               rstN,
  input logic               nWaitReq,
  input logic               nError,
  input logic [WADDR_W-1:0] wAddr,
  input logic               wRead,
  input logic               wWrite,
  input logic [WB-1:0]      wByteEn,
  input logic [WIDE_W-1:0]  wWriteData,
  input logic               wWaitReq
);

  logic wideReq;
  assign wideReq = wRead | wWrite;

  p_rw_exclusive_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(wRead && wWrite));

  p_one_half_r3: assert property (@(posedge clk) disable iff (!rstN)
    wideReq |-> ((wByteEn[NB-1:0] == '0) != (wByteEn[WB-1:NB] == '0)));

  p_fault_not_forwarded_r6: assert property (@(posedge clk) disable iff (!rstN)
    nError |-> (!wideReq && !nWaitReq));

  p_hold_while_stalled_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wideReq && wWaitReq) |=> (wideReq && $stable(wRead) && $stable(wAddr)
                               && $stable(wByteEn) && $stable(wWriteData)));

  p_ack_after_accept_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wideReq && !wWaitReq) |=> (!nWaitReq && !nError && !wideReq));

  p_ack_single_cycle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !nWaitReq |=> nWaitReq);

  p_lane_count_r9: assert property (@(posedge clk) disable iff (!rstN)
    wideReq |-> ($countones(wByteEn) == 1 || $countones(wByteEn) == 2
                 || $countones(wByteEn) == 4));

endmodule

bind bus_width_bridge bwb_checker #(
  .ADDR_W   (ADDR_W),
  .NARROW_W (NARROW_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .nWaitReq   (nWaitReq),
  .nError     (nError),
  .wAddr      (wAddr),
  .wRead      (wRead),
  .wWrite     (wWrite),
  .wByteEn    (wByteEn),
  .wWriteData (wWriteData),
  .wWaitReq   (wWaitReq)
);

// File: tb/bus_width_bridge_tb.sv
`timescale 1ns/1ps
module bus_width_bridge_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:2] nAddr = '0;
  logic        nRead = 1'b0;
  logic        nWrite = 1'b0;
  logic [3:0]  nByteEn = '0;
  logic [31:0] nWriteData = '0;
  logic [31:0] nReadData;
  logic        nWaitReq;
  logic        nError;
  logic [12:0] wAddr;
  logic        wRead;
  logic        wWrite;
  logic [7:0]  wByteEn;
  logic [63:0] wWriteData;
  logic [63:0] wReadData = '0;
  logic        wWaitReq = 1'b1;

  logic [63:0] mem [8];
  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bus_width_bridge u_dut (
    .clk(clk), .rstN(rstN), .nAddr(nAddr), .nRead(nRead), .nWrite(nWrite),
    .nByteEn(nByteEn), .nWriteData(nWriteData), .nReadData(nReadData),
    .nWaitReq(nWaitReq), .nError(nError), .wAddr(wAddr), .wRead(wRead),
    .wWrite(wWrite), .wByteEn(wByteEn), .wWriteData(wWriteData),
    .wReadData(wReadData), .wWaitReq(wWaitReq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Runs one narrow access against a modelled wide slave.
  task automatic access(input logic [15:0] addr, input logic [3:0] be,
                        input logic [31:0] data, input bit rd, input int waits,
                        input bit scramble, input string req,
                        output logic [31:0] rdata, output bit err,
                        output int strobeCycles, output int ackAt);
    logic [12:0] expAddr;
    logic [7:0]  expBe;
    int waited;
    bit got;
    expAddr = addr[15:3];
    expBe   = addr[2] ? {be, 4'b0000} : {4'b0000, be};
    @(negedge clk);
    nAddr = addr[15:2]; nByteEn = be; nWriteData = data;
    nRead = rd; nWrite = !rd; wWaitReq = 1'b1;
    waited = 0; got = 1'b0; strobeCycles = 0; ackAt = -1; rdata = '0; err = 1'b0;
    for (int c = 0; c < 40 && !got; c++) begin
      @(negedge clk);
      if (scramble && c == 0) nAddr = addr[15:2] ^ 14'h1;
      if (wRead || wWrite) begin
        strobeCycles++;
        chk(wAddr == expAddr, "R2", "wide address", 64'(wAddr), 64'(expAddr));
        chk(wByteEn == expBe, "R3", "wide byte-enable", 64'(wByteEn), 64'(expBe));
        chk(wRead == rd && wWrite == !rd, "R1", "strobe kind", {wRead, wWrite}, {rd, !rd});
        if (!rd) chk(wWriteData == {data, data}, "R4", "duplicated write data",
                     wWriteData, {data, data});
        if (waited < waits) begin
          wWaitReq = 1'b1; waited++;
        end else begin
          wWaitReq = 1'b0;
          if (wWrite) begin
            for (int l = 0; l < 8; l++)
              if (wByteEn[l]) mem[wAddr[2:0]][l*8 +: 8] = wWriteData[l*8 +: 8];
          end else begin
            wReadData = mem[wAddr[2:0]];
          end
        end
      end else begin
        wWaitReq = 1'b1;
      end
      if (!nWaitReq) begin
        rdata = nReadData; err = nError; got = 1'b1; ackAt = c;
        nRead = 1'b0; nWrite = 1'b0;
      end
    end
    @(negedge clk);
    chk(nWaitReq == 1'b1, "R8", "wait-request high after ack", 64'(nWaitReq), 64'd1);
  endtask

  task automatic doWrite(input logic [15:0] addr, input logic [3:0] be,
                         input logic [31:0] data, input int waits, input string req);
    logic [31:0] rdata; bit err; int sc; int ack;
    access(addr, be, data, 1'b0, waits, 1'b0, req, rdata, err, sc, ack);
    chk(err == 1'b0, req, "no error on legal write", 64'(err), 64'd0);
    chk(sc == waits + 1, "R7", "wide strobe cycles", 64'(sc), 64'(waits + 1));
    chk(ack == waits + 1, "R8", "ack cycle", 64'(ack), 64'(waits + 1));
  endtask

  task automatic doRead(input logic [15:0] addr, input logic [3:0] be,
                        input logic [31:0] exp, input int waits, input bit scramble,
                        input string req);
    logic [31:0] rdata; bit err; int sc; int ack;
    access(addr, be, 32'h0, 1'b1, waits, scramble, req, rdata, err, sc, ack);
    chk(rdata == exp, req, "read data", 64'(rdata), 64'(exp));
    chk(sc == waits + 1, "R7", "wide strobe cycles", 64'(sc), 64'(waits + 1));
  endtask

  task automatic testReset();
    chk(!wRead && !wWrite, "R1", "no wide strobe after reset", {wRead, wWrite}, 64'd0);
    chk(nError == 1'b0, "R1", "error low after reset", 64'(nError), 64'd0);
    chk(nWaitReq == 1'b1, "R1", "wait-request high after reset", 64'(nWaitReq), 64'd1);
  endtask

  task automatic testWordLanes();
    doWrite(16'h0000, 4'b1111, 32'h11223344, 0, "R3");
    doWrite(16'h0004, 4'b1111, 32'h55667788, 2, "R7");
    chk(mem[0] == 64'h55667788_11223344, "R3", "wide word after two halves",
        mem[0], 64'h55667788_11223344);
    doRead(16'h0000, 4'b1111, 32'h11223344, 0, 1'b0, "R5");
    doRead(16'h0004, 4'b1111, 32'h55667788, 1, 1'b0, "R5");
  endtask

  task automatic testLatchedRead();
    doRead(16'h0004, 4'b1111, 32'h55667788, 3, 1'b1, "R5");
    doRead(16'h0000, 4'b1111, 32'h11223344, 2, 1'b1, "R5");
  endtask

  task automatic testSubWord();
    doWrite(16'h0013, 4'b1000, 32'hAB000000, 0, "R9");
    doWrite(16'h001E, 4'b1100, 32'hCDEF0000, 1, "R9");
    doWrite(16'h0021, 4'b0010, 32'h00005A00, 0, "R9");
    doRead(16'h0010, 4'b1111, 32'hAB000000, 0, 1'b0, "R9");
    doRead(16'h001C, 4'b1111, 32'hCDEF0000, 0, 1'b0, "R9");
    doRead(16'h0018, 4'b1111, 32'h00000000, 0, 1'b0, "R9");
    doRead(16'h0020, 4'b0011, 32'h00005A00, 0, 1'b0, "R9");
  endtask

  task automatic testIllegal();
    logic [3:0] bad [3] = '{4'b0110, 4'b0111, 4'b0000};
    foreach (bad[i]) begin
      logic [31:0] rdata; bit err; int sc; int ack;
      access(16'h0008, bad[i], 32'hFFFFFFFF, 1'b0, 0, 1'b0, "R6", rdata, err, sc, ack);
      chk(err == 1'b1, "R6", "error flag on refused pattern", 64'(err), 64'd1);
      chk(sc == 0, "R6", "no wide strobe on refused pattern", 64'(sc), 64'd0);
      chk(ack == 0, "R6", "immediate one-cycle ack", 64'(ack), 64'd0);
    end
    doRead(16'h0008, 4'b1111, 32'h00000000, 0, 1'b0, "R6");
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    foreach (mem[i]) mem[i] = '0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWordLanes();
    testLatchedRead();
    testSubWord();
    testIllegal();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule